// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Sensed Dead Time

This block turns a single digital switching request into two gate enables for the high-side and low-side transistors of a synchronous step-down power stage. The request normally comes from a comparator that sets the error signal against a fixed-frequency ramp near 300 kHz. The block never drives both transistors at once. It does not wait a fixed time between the two. Instead it holds both gates off until a sense flag reports that the gate being released has actually dropped below its threshold. Only then does it enable the other gate. This lets the dead time follow the real gate discharge of whatever transistors are fitted.

The request may stay high or low for any number of periods, so the full range from no high-side conduction to constant high-side conduction is supported. Outside the high phase the low side is the resting switch, because its conduction recharges the floating supply of the high-side driver. An inhibit from the start-up sequencer forces both gates off. If a sense flag does not arrive within a programmable number of cycles, the block parks both gates off and latches a fault. The fault stays latched until inhibit or reset.

Top module: `hb_gate_sequencer`

## Requirements
- R1: `hi_en` and `lo_en` are never both high in the same cycle.
- R2: `hi_en` rises only at a clock edge where `lo_off_sense` was sampled high and `lo_en` was low in the cycle before that edge. After `pwm_req` rises while the low side is on, there is at least one cycle with both enables low.
- R3: `lo_en` rises only at a clock edge where `hi_off_sense` was sampled high and `hi_en` was low in the cycle before that edge.
- R4: While `rst` or `inhibit` is high, the edge that follows drives `hi_en`, `lo_en` and `fault` low.
- R5: After `inhibit` or `rst` falls, both enables stay low for the first edge. A gate can turn on no earlier than the second edge, and only once its opposite sense flag is seen.
- R6: While `pwm_req` stays high and the high side is on, `hi_en` stays high every cycle, whatever the sense flags do (100% duty).
- R7: While `pwm_req` stays low and the low side is on, `lo_en` stays high every cycle, whatever the sense flags do (0% duty).
- R8: Each wait for a sense flag starts a count at 0. If the awaited flag is still low in the wait cycle whose count equals `timeout_lim`, then `fault` goes high at the next edge with both enables low. With a limit of L, the fault appears L+1 edges after the wait was entered.
- R9: Once `fault` is high, it stays high and both enables stay low regardless of `pwm_req` and the sense flags, until `inhibit` or `rst` clears it.
- R10: If `pwm_req` reverses while a switch is waiting for its sense flag, the wait is abandoned. The block then waits for the other direction, and a reversed request takes priority over a sense flag seen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inhibit | input | 1 | Start-up sequencer hold; both gates off while high |
| pwm_req | input | 1 | 1 requests high-side conduction, 0 low-side |
| hi_off_sense | input | 1 | 1 when the high-side gate is sensed below threshold |
| lo_off_sense | input | 1 | 1 when the low-side gate is sensed below threshold |
| timeout_lim | input | TMO_W | Wait cycles allowed for a sense flag (count compared against this value) |
| hi_en | output | 1 | High-side gate enable |
| lo_en | output | 1 | Low-side gate enable |
| fault | output | 1 | Latched sense-timeout fault |

## Verification
The bench holds a sense flag low for several cycles and checks that the complementary enable stays low until the flag arrives. A design that used a fixed delay, or that ignored the flag, would turn the gate on early and conduct through both switches. It runs the timeout with limits of 0 and 3 and checks the exact edge where the fault appears; an off-by-one counter would fault a cycle early or late. It reverses the request in the same cycle a sense flag arrives; a design that ranks the flag first would enable the wrong gate. It also holds the request at each extreme while the flags toggle, and then drives random requests against gates with random discharge delays, checking exclusion and the sensed-off precondition on every cycle.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [2:0] {
        GS_IDLE    = 3'd0,
        GS_WAIT_LO = 3'd1,
        GS_HI      = 3'd2,
        GS_WAIT_HI = 3'd3,
        GS_LO      = 3'd4,
        GS_FAULT   = 3'd5
    } gs_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic flt;
    } gs_drive_t;

    function automatic gs_drive_t gs_decode(gs_state_t s);
        gs_drive_t d;
        d.hi  = (s == GS_HI);
        d.lo  = (s == GS_LO);
        d.flt = (s == GS_FAULT);
        return d;
    endfunction

    function automatic logic gs_is_wait(gs_state_t s);
        return (s == GS_WAIT_LO) || (s == GS_WAIT_HI);
    endfunction

endpackage

// File: rtl/hb_wait_timer.sv
module hb_wait_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [TMO_W-1:0] lim,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    assign expired = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hb_phase_fsm.sv
module hb_phase_fsm
    import hb_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      inhibit,
    input  logic      pwm_req,
    input  logic      hi_off_sense,
    input  logic      lo_off_sense,
    input  logic      expired,
    output logic      tmr_clr,
    output gs_state_t state
);
    gs_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            GS_IDLE:    nxt = pwm_req ? GS_WAIT_LO : GS_WAIT_HI;
            GS_WAIT_LO: begin
                if (!pwm_req)          nxt = GS_WAIT_HI;
                else if (lo_off_sense) nxt = GS_HI;
                else if (expired)      nxt = GS_FAULT;
            end
            GS_HI:      if (!pwm_req) nxt = GS_WAIT_HI;
            GS_WAIT_HI: begin
                if (pwm_req)           nxt = GS_WAIT_LO;
                else if (hi_off_sense) nxt = GS_LO;
                else if (expired)      nxt = GS_FAULT;
            end
            GS_LO:      if (pwm_req) nxt = GS_WAIT_LO;
            GS_FAULT:   nxt = GS_FAULT;
            default:    nxt = GS_IDLE;
        endcase
        if (inhibit) nxt = GS_IDLE;
    end

    assign tmr_clr = (nxt != state) || !gs_is_wait(state);

    always_ff @(posedge clk) begin
        if (rst) state <= GS_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hb_gate_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inhibit,
    input  logic             pwm_req,
    input  logic             hi_off_sense,
    input  logic             lo_off_sense,
    input  logic [TMO_W-1:0] timeout_lim,
    output logic             hi_en,
    output logic             lo_en,
    output logic             fault
);
    gs_state_t state;
    gs_drive_t drv;
    logic      tmr_clr;
    logic      expired;

    hb_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .inhibit      (inhibit),
        .pwm_req      (pwm_req),
        .hi_off_sense (hi_off_sense),
        .lo_off_sense (lo_off_sense),
        .expired      (expired),
        .tmr_clr      (tmr_clr),
        .state        (state)
    );

    hb_wait_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .lim     (timeout_lim),
        .expired (expired)
    );

    assign drv   = gs_decode(state);
    assign hi_en = drv.hi;
    assign lo_en = drv.lo;
    assign fault = drv.flt;
endmodule

// File: rtl/hb_gate_sequencer_chk.sv
module hb_gate_sequencer_chk (
    input logic clk,
    input logic rst,
    input logic inhibit,
    input logic hi_off_sense,
    input logic lo_off_sense,
    input logic hi_en,
    input logic lo_en,
    input logic fault
);
    p_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(hi_en && lo_en));

    p_hi_sensed_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_en) |-> ($past(lo_off_sense) && !$past(lo_en)));

    p_lo_sensed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_en) |-> ($past(hi_off_sense) && !$past(hi_en)));

    p_inhibit_off_r4: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (!hi_en && !lo_en && !fault));

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!hi_en && !lo_en));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (fault && !inhibit) |=> fault);
endmodule

bind hb_gate_sequencer hb_gate_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .inhibit      (inhibit),
    .hi_off_sense (hi_off_sense),
    .lo_off_sense (lo_off_sense),
    .hi_en        (hi_en),
    .lo_en        (lo_en),
    .fault        (fault)
);

// File: tb/sim_hb_gate_sequencer.sv
`timescale 1ns/1ps
module sim_hb_gate_sequencer;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             inhibit = 1'b0;
    logic             pwm_req = 1'b0;
    logic             hi_off_sense = 1'b0;
    logic             lo_off_sense = 1'b0;
    logic [TMO_W-1:0] timeout_lim = 8'd3;
    logic             hi_en, lo_en, fault;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  h;
        logic  l;
        logic  f;
        string tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    hb_gate_sequencer #(.TMO_W(TMO_W)) u0 (
        .clk          (clk),
        .rst          (rst),
        .inhibit      (inhibit),
        .pwm_req      (pwm_req),
        .hi_off_sense (hi_off_sense),
        .lo_off_sense (lo_off_sense),
        .timeout_lim  (timeout_lim),
        .hi_en        (hi_en),
        .lo_en        (lo_en),
        .fault        (fault)
    );

    // Monitor: compare outputs shortly after each edge against queued items
    always @(posedge clk) begin
        #2;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hi_en !== e.h || lo_en !== e.l || fault !== e.f) begin
                fails++;
                $display("FAIL %s: hi/lo/fault got %b%b%b expected %b%b%b",
                         e.tag, hi_en, lo_en, fault, e.h, e.l, e.f);
            end
        end
    end

    task automatic step(input logic r, input logic inh, input logic p,
                        input logic hs, input logic ls,
                        input logic eh, input logic el, input logic ef,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; inhibit = inh; pwm_req = p;
        hi_off_sense = hs; lo_off_sense = ls;
        e.h = eh; e.l = el; e.f = ef; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic chk(input logic cond, input string tag, input string msg);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not end, got hung expected done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // reset and inhibit (R4)
        step(1,0,1,1,1, 0,0,0, "R4 reset");
        step(1,0,1,1,1, 0,0,0, "R4 reset");
        step(0,1,1,1,1, 0,0,0, "R4 inhibit");
        step(0,1,1,1,1, 0,0,0, "R4 inhibit");
        // leave inhibit, low side comes up (R5, R7)
        step(0,0,0,1,0, 0,0,0, "R5 first edge both off");
        step(0,0,0,1,0, 0,1,0, "R7 low side on");
        step(0,0,0,0,1, 0,1,0, "R7 sense ignored");
        // rise of request, wait for low-side off (R2)
        step(0,0,1,1,0, 0,0,0, "R2 wait lo off");
        step(0,0,1,1,0, 0,0,0, "R2 still waiting");
        step(0,0,1,1,1, 1,0,0, "R2 hi on after sense");
        // 100% duty (R6)
        step(0,0,1,0,0, 1,0,0, "R6 hold hi");
        step(0,0,1,1,0, 1,0,0, "R6 hold hi");
        step(0,0,1,0,1, 1,0,0, "R6 hold hi");
        // fall of request (R3)
        step(0,0,0,0,1, 0,0,0, "R3 wait hi off");
        step(0,0,0,0,1, 0,0,0, "R3 still waiting");
        step(0,0,0,1,1, 0,1,0, "R3 lo on after sense");
        // reversal during a wait (R10)
        step(0,0,1,1,1, 0,0,0, "R10 enter wait lo");
        step(0,0,0,1,1, 0,0,0, "R10 reversal beats sense");
        step(0,0,0,1,1, 0,1,0, "R10 lo resumes");
        // timeout with limit 3 (R8)
        step(0,0,1,1,0, 0,0,0, "R8 wait c0");
        step(0,0,1,1,0, 0,0,0, "R8 wait c1");
        step(0,0,1,1,0, 0,0,0, "R8 wait c2");
        step(0,0,1,1,0, 0,0,0, "R8 wait c3");
        step(0,0,1,1,0, 0,0,1, "R8 fault raised");
        // fault latched (R9)
        step(0,0,1,1,1, 0,0,1, "R9 fault holds");
        step(0,0,0,1,1, 0,0,1, "R9 fault holds");
        step(0,1,0,1,1, 0,0,0, "R9 inhibit clears");
        // leave inhibit toward high side (R5)
        step(0,0,1,1,1, 0,0,0, "R5 first edge both off");
        step(0,0,1,1,1, 1,0,0, "R5 hi after second edge");
        // inhibit while high side on (R4)
        step(0,1,1,1,1, 0,0,0, "R4 inhibit drops hi");
        step(0,0,1,1,1, 0,0,0, "R5 first edge both off");
        step(0,0,1,1,1, 1,0,0, "R5 hi again");
        // timeout limit 0 on the high-side wait (R8)
        @(negedge clk); timeout_lim = 8'd0;
        step(0,0,0,0,1, 0,0,0, "R8 lim0 wait c0");
        step(0,0,0,0,1, 0,0,1, "R8 lim0 fault");
        step(1,0,0,0,1, 0,0,0, "R4 reset clears fault");
        @(negedge clk);
        timeout_lim = 8'd20;
        rst = 1'b0;

        // random phase: gates modelled with discharge delays of 1..4 cycles
        begin
            int hoff = 8, loff = 8, dh = 2, dl = 3, hold = 0;
            logic ph = 0, pl = 0, pls = 0, phs = 0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                chk(!(hi_en && lo_en), "R1", "both enables high, expected exclusive");
                if (hi_en && !ph)
                    chk(pls && !pl, "R2", "hi rose without lo sensed off");
                if (lo_en && !pl)
                    chk(phs && !ph, "R3", "lo rose without hi sensed off");
                chk(!fault, "R8", "fault with sense inside limit, expected none");
                ph = hi_en; pl = lo_en;
                hoff = hi_en ? 0 : ((hoff < 8) ? hoff + 1 : hoff);
                loff = lo_en ? 0 : ((loff < 8) ? loff + 1 : loff);
                if (i % 50 == 0) begin
                    dh = $urandom_range(1, 4);
                    dl = $urandom_range(1, 4);
                end
                if (hold == 0) begin
                    pwm_req = $urandom_range(0, 1);
                    hold = $urandom_range(1, 6);
                end else begin
                    hold--;
                end
                hi_off_sense = (hoff >= dh);
                lo_off_sense = (loff >= dl);
                phs = hi_off_sense; pls = lo_off_sense;
            end
        end

        @(posedge clk); #3;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule